// File: doc/BRIEF.md
# UART Register Front-End

This block is the bus-facing register decoder of a serial port. It sits on a simple 32-bit peripheral bus with a 4 KB window and an APB-style two-phase handshake. It holds the configuration registers: line format, control, baud divisors, FIFO trigger level, interrupt mask, DMA control and the low-power divisor. It also serves a fixed identification signature at the top of the window. The receive and transmit FIFOs and the interrupt logic sit outside the block. The block sends them single-cycle strobes and receives their status.

Every access finishes in its enable phase with no wait states. Read data is valid during that phase, and every side-effect strobe is asserted combinationally in that same cycle. A read of the data register pops the receive FIFO and latches the error bits of the word it returns. A line-control write that changes the FIFO mode flushes the FIFOs. A line-control write that changes the break bit reports a break transition. In loopback mode, transmitted bytes and break markers are sent back into the receive FIFO.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the FIFO level register (offset 0x034) reads 0x12. The receive status, divisors, line control, control, mask, masked status, DMA control and low-power registers read 0. The raw status (0x03C) reads the `ris` input.
- R2: Word offsets 0xFE0 through 0xFFC read the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, indexed by (offset − 0xFE0)/4. Writes to them have no effect.
- R3: A read of offset 0x000 returns `rx_head` (data in bits 7:0, error flags in bits 11:8). It asserts `rx_pop` in the enable phase when `rx_empty` is 0. The error flags of that word are then readable at the receive status offset 0x004.
- R4: Any write to 0x004 clears the receive status. Writes to the flag register 0x018 are ignored. The flag register reads busy at bit 3, rx_empty at bit 4, tx_full at bit 5, rx_full at bit 6 and tx_empty at bit 7, all taken from the inputs.
- R5: A write to line control (0x02C) whose FIFO-enable bit (bit 4) differs from the held value pulses `fifo_flush` in the enable phase. A write that leaves bit 4 unchanged does not.
- R6: A line-control write whose break bit (bit 0) differs from the held value pulses `break_toggle`. When the write sets the bit while loopback (control bit 7) is on, `rx_push` fires with the break word 0x400 (error bit 10 set, data 0).
- R7: A write to 0x000 pulses `tx_push` with `tx_byte` equal to write bits 7:0. With loopback on, it also pulses `rx_push` with that byte, zero-extended, as the word.
- R8: The integer divisor (0x024) keeps 16 bits and the fractional divisor (0x028) keeps 6 bits. The FIFO level (0x034) and DMA control (0x048) keep 6 and 3 bits, the low-power divisor (0x020) 8 bits, and the mask (0x038) 11 bits.
- R9: Unmapped offsets read 0. A write to them changes no register and fires no strobe.
- R10: The masked status (0x040) reads `ris` AND mask. A write to the clear offset 0x044 pulses `irq_clear` with `irq_clear_bits` equal to the write data. Writes to 0x03C and 0x040 are ignored.
- R11: No strobe fires during the setup phase of an access, that is, while `psel` is high and `penable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Enable (access) phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| rx_head | input | 12 | Receive FIFO head word (errors in 11:8) |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_busy | input | 1 | Transmitter busy |
| ris | input | 11 | Raw interrupt status from interrupt logic |
| rx_pop | output | 1 | Pop the receive FIFO |
| rx_push | output | 1 | Push a loopback word into the receive FIFO |
| rx_push_word | output | 12 | Word for rx_push |
| tx_push | output | 1 | Push a byte into the transmit FIFO |
| tx_byte | output | 8 | Byte for tx_push |
| fifo_flush | output | 1 | Flush both FIFOs |
| break_toggle | output | 1 | Break bit changed |
| line_ctrl | output | 8 | Line control register |
| uart_ctrl | output | 16 | Control register |
| baud_int | output | 16 | Integer baud divisor |
| baud_frac | output | 6 | Fractional baud divisor |
| fifo_lvl | output | 6 | FIFO trigger level |
| irq_mask | output | 11 | Interrupt mask |
| irq_clear | output | 1 | Interrupt clear strobe |
| irq_clear_bits | output | 11 | Bits to clear |
| dma_ctrl | output | 3 | DMA control |
| lp_div | output | 8 | Low-power divisor |

## Verification
A wrong held line-control value is first seen on the next line-control write: a flush or break pulse goes missing, or one fires that should not. The `line_ctrl` output shows the wrong value from the cycle after the write. A receive-status latch that misses a pop shows a stale error nibble on the next status read, a few cycles later. A decode fault shows immediately as wrong read data or a stray strobe. For that reason the bench sweeps every word offset for both reads and writes, and it checks the strobes in the same enable cycle.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int ADDR_W    = 12;
    localparam int LINE_W    = 8;
    localparam int CTRL_W    = 16;
    localparam int BINT_W    = 16;
    localparam int BFRAC_W   = 6;
    localparam int LEVEL_W   = 6;
    localparam int DMA_W     = 3;
    localparam int LPDIV_W   = 8;

    localparam int LINE_BRK_BIT = 0;
    localparam int LINE_FEN_BIT = 4;
    localparam int CTRL_LB_BIT  = 7;

    localparam logic [LEVEL_W-1:0] LEVEL_RST = 6'h12;

    typedef enum logic [3:0] {
        RS_NONE, RS_DATA, RS_RSTAT, RS_FLAG, RS_LPDIV, RS_BINT, RS_BFRAC,
        RS_LINE, RS_CTRL, RS_LEVEL, RS_MASK, RS_RAW, RS_MSKD, RS_CLR, RS_DMA
    } reg_sel_e;

    // Identification signature, byte i at offset 0xFE0 + 4*i
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    id_byte = 8'h11;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              id_hit,
    output logic [2:0]        id_idx
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    assign widx   = addr[ADDR_W-1:2];
    assign id_hit = (addr[ADDR_W-1:5] == '1);
    assign id_idx = addr[4:2];

    always_comb begin
        case (widx)
            10'd0:   sel = RS_DATA;
            10'd1:   sel = RS_RSTAT;
            10'd6:   sel = RS_FLAG;
            10'd8:   sel = RS_LPDIV;
            10'd9:   sel = RS_BINT;
            10'd10:  sel = RS_BFRAC;
            10'd11:  sel = RS_LINE;
            10'd12:  sel = RS_CTRL;
            10'd13:  sel = RS_LEVEL;
            10'd14:  sel = RS_MASK;
            10'd15:  sel = RS_RAW;
            10'd16:  sel = RS_MSKD;
            10'd17:  sel = RS_CLR;
            10'd18:  sel = RS_DMA;
            default: sel = RS_NONE;
        endcase
    end

    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/uart_rf_idrom.sv
module uart_rf_idrom
    import uart_rf_pkg::*;
(
    input  logic [2:0] idx,
    output logic [7:0] val
);
    assign val = id_byte(idx);
endmodule

// File: rtl/uart_rf_linewatch.sv
module uart_rf_linewatch
    import uart_rf_pkg::*;
(
    input  logic              wr_line,
    input  logic [LINE_W-1:0] line_q,
    input  logic [LINE_W-1:0] line_new,
    input  logic              loopback,
    output logic              flush,
    output logic              brk_toggle,
    output logic              brk_push
);
    always_comb begin
        flush      = wr_line && (line_q[LINE_FEN_BIT] != line_new[LINE_FEN_BIT]);
        brk_toggle = wr_line && (line_q[LINE_BRK_BIT] != line_new[LINE_BRK_BIT]);
        brk_push   = brk_toggle && line_new[LINE_BRK_BIT] && loopback;
    end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4,
    parameter int IRQ_W  = 11,
    parameter int BUS_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [BUS_W-1:0]          pwdata,
    output logic [BUS_W-1:0]          prdata,
    input  logic [DATA_W+ERR_W-1:0]   rx_head,
    input  logic                      rx_empty,
    input  logic                      rx_full,
    input  logic                      tx_empty,
    input  logic                      tx_full,
    input  logic                      tx_busy,
    input  logic [IRQ_W-1:0]          ris,
    output logic                      rx_pop,
    output logic                      rx_push,
    output logic [DATA_W+ERR_W-1:0]   rx_push_word,
    output logic                      tx_push,
    output logic [DATA_W-1:0]         tx_byte,
    output logic                      fifo_flush,
    output logic                      break_toggle,
    output logic [LINE_W-1:0]         line_ctrl,
    output logic [CTRL_W-1:0]         uart_ctrl,
    output logic [BINT_W-1:0]         baud_int,
    output logic [BFRAC_W-1:0]        baud_frac,
    output logic [LEVEL_W-1:0]        fifo_lvl,
    output logic [IRQ_W-1:0]          irq_mask,
    output logic                      irq_clear,
    output logic [IRQ_W-1:0]          irq_clear_bits,
    output logic [DMA_W-1:0]          dma_ctrl,
    output logic [LPDIV_W-1:0]        lp_div
);
    localparam int WORD_W = DATA_W + ERR_W;
    localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << (DATA_W + 2);

    typedef struct packed {
        logic [ERR_W-1:0]   rsr;
        logic [LPDIV_W-1:0] lpdiv;
        logic [BINT_W-1:0]  bint;
        logic [BFRAC_W-1:0] bfrac;
        logic [LINE_W-1:0]  line;
        logic [CTRL_W-1:0]  ctrl;
        logic [LEVEL_W-1:0] level;
        logic [IRQ_W-1:0]   mask;
        logic [DMA_W-1:0]   dma;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     id_hit;
    logic [2:0] id_idx;
    logic [7:0] id_val;
    logic     acc, wr, rd;
    logic     wr_line;
    logic     lb_on;
    logic     brk_push;
    logic [BUS_W-1:0] rdata;

    uart_rf_decode u_dec (
        .addr   (paddr),
        .sel    (sel),
        .id_hit (id_hit),
        .id_idx (id_idx)
    );

    uart_rf_idrom u_id (
        .idx (id_idx),
        .val (id_val)
    );

    assign acc     = psel && penable;
    assign wr      = acc && pwrite;
    assign rd      = acc && !pwrite;
    assign wr_line = wr && (sel == RS_LINE);
    assign lb_on   = regs_q.ctrl[CTRL_LB_BIT];

    uart_rf_linewatch u_lw (
        .wr_line    (wr_line),
        .line_q     (regs_q.line),
        .line_new   (pwdata[LINE_W-1:0]),
        .loopback   (lb_on),
        .flush      (fifo_flush),
        .brk_toggle (break_toggle),
        .brk_push   (brk_push)
    );

    // Next-state computation
    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (sel)
                RS_RSTAT: regs_d.rsr   = '0;
                RS_LPDIV: regs_d.lpdiv = pwdata[LPDIV_W-1:0];
                RS_BINT:  regs_d.bint  = pwdata[BINT_W-1:0];
                RS_BFRAC: regs_d.bfrac = pwdata[BFRAC_W-1:0];
                RS_LINE:  regs_d.line  = pwdata[LINE_W-1:0];
                RS_CTRL:  regs_d.ctrl  = pwdata[CTRL_W-1:0];
                RS_LEVEL: regs_d.level = pwdata[LEVEL_W-1:0];
                RS_MASK:  regs_d.mask  = pwdata[IRQ_W-1:0];
                RS_DMA:   regs_d.dma   = pwdata[DMA_W-1:0];
                default:  ;
            endcase
        end
        if (rd && sel == RS_DATA)
            regs_d.rsr = rx_head[WORD_W-1 -: ERR_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.level <= LEVEL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (id_hit) begin
            rdata = BUS_W'(id_val);
        end else begin
            case (sel)
                RS_DATA:  rdata = BUS_W'(rx_head);
                RS_RSTAT: rdata = BUS_W'(regs_q.rsr);
                RS_FLAG:  rdata = BUS_W'({tx_empty, rx_full, tx_full, rx_empty, tx_busy, 3'b000});
                RS_LPDIV: rdata = BUS_W'(regs_q.lpdiv);
                RS_BINT:  rdata = BUS_W'(regs_q.bint);
                RS_BFRAC: rdata = BUS_W'(regs_q.bfrac);
                RS_LINE:  rdata = BUS_W'(regs_q.line);
                RS_CTRL:  rdata = BUS_W'(regs_q.ctrl);
                RS_LEVEL: rdata = BUS_W'(regs_q.level);
                RS_MASK:  rdata = BUS_W'(regs_q.mask);
                RS_RAW:   rdata = BUS_W'(ris);
                RS_MSKD:  rdata = BUS_W'(ris & regs_q.mask);
                RS_DMA:   rdata = BUS_W'(regs_q.dma);
                default:  rdata = '0;
            endcase
        end
    end

    assign prdata = (psel && !pwrite) ? rdata : '0;

    // Strobes toward FIFOs and interrupt logic
    always_comb begin
        rx_pop         = rd && (sel == RS_DATA) && !rx_empty;
        tx_push        = wr && (sel == RS_DATA);
        tx_byte        = pwdata[DATA_W-1:0];
        rx_push        = (tx_push && lb_on) || brk_push;
        rx_push_word   = brk_push ? BRK_WORD : WORD_W'(pwdata[DATA_W-1:0]);
        irq_clear      = wr && (sel == RS_CLR);
        irq_clear_bits = pwdata[IRQ_W-1:0];
    end

    assign line_ctrl = regs_q.line;
    assign uart_ctrl = regs_q.ctrl;
    assign baud_int  = regs_q.bint;
    assign baud_frac = regs_q.bfrac;
    assign fifo_lvl  = regs_q.level;
    assign irq_mask  = regs_q.mask;
    assign dma_ctrl  = regs_q.dma;
    assign lp_div    = regs_q.lpdiv;

    logic unused_wdata;
    assign unused_wdata = ^pwdata;

    // R3
    rsr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> regs_q.rsr == $past(rx_head[WORD_W-1 -: ERR_W]));

    // R5
    flush_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> line_ctrl[LINE_FEN_BIT] != $past(line_ctrl[LINE_FEN_BIT]));

    // R6
    brk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !tx_push) |=> (line_ctrl[LINE_BRK_BIT] && uart_ctrl[CTRL_LB_BIT]));

    // R7
    tx_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && uart_ctrl[CTRL_LB_BIT]) |-> (rx_push && rx_push_word[DATA_W-1:0] == tx_byte));

    // R11
    no_setup_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |-> !(rx_pop || rx_push || tx_push || fifo_flush || break_toggle || irq_clear));

    // R1
    level_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> fifo_lvl == LEVEL_RST);
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic [11:0] rx_head = 0;
    logic        rx_empty = 1, rx_full = 0, tx_empty = 1, tx_full = 0, tx_busy = 0;
    logic [10:0] ris = 11'h2A5;
    logic        rx_pop, rx_push, tx_push, fifo_flush, break_toggle, irq_clear;
    logic [11:0] rx_push_word;
    logic [7:0]  tx_byte, line_ctrl, lp_div;
    logic [15:0] uart_ctrl, baud_int;
    logic [5:0]  baud_frac, fifo_lvl;
    logic [10:0] irq_mask, irq_clear_bits;
    logic [2:0]  dma_ctrl;

    int total = 0, bad = 0;
    bit done = 0;

    // strobe snapshots from the last enable phase
    logic s_pop, s_push, s_tx, s_flush, s_brk, s_clr, s_setup;
    logic [11:0] s_word;
    logic [7:0]  s_byte;
    logic [10:0] s_clrbits;

    always #2.5 clk = ~clk;

    uart_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_head(rx_head),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full),
        .tx_busy(tx_busy), .ris(ris), .rx_pop(rx_pop), .rx_push(rx_push),
        .rx_push_word(rx_push_word), .tx_push(tx_push), .tx_byte(tx_byte),
        .fifo_flush(fifo_flush), .break_toggle(break_toggle), .line_ctrl(line_ctrl),
        .uart_ctrl(uart_ctrl), .baud_int(baud_int), .baud_frac(baud_frac),
        .fifo_lvl(fifo_lvl), .irq_mask(irq_mask), .irq_clear(irq_clear),
        .irq_clear_bits(irq_clear_bits), .dma_ctrl(dma_ctrl), .lp_div(lp_div)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic snap();
        s_pop = rx_pop; s_push = rx_push; s_word = rx_push_word; s_tx = tx_push;
        s_byte = tx_byte; s_flush = fifo_flush; s_brk = break_toggle;
        s_clr = irq_clear; s_clrbits = irq_clear_bits;
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rv);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        #1 s_setup = rx_pop | rx_push | tx_push | fifo_flush | break_toggle | irq_clear;
        @(negedge clk);
        penable = 1;
        #1 rv = prdata; snap();
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus(1'b1, a, d, dummy);
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] v);
        bus(1'b0, a, 32'h0, v);
    endtask

    function automatic bit is_mapped(input int w);
        return (w <= 1) || (w == 6) || (w >= 8 && w <= 18);
    endfunction

    function automatic logic [31:0] exp_reset(input int w);
        logic [7:0] idt [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (w >= 12'h3F8) return {24'h0, idt[w - 12'h3F8]};
        case (w)
            6:  return 32'h90;
            13: return 32'h12;
            15: return {21'h0, ris};
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 R2 R9: read every word offset after reset
        for (int w = 0; w < 1024; w++) begin
            rd32(12'(w * 4), v);
            if (w >= 12'h3F8) check("R2 id byte", v, exp_reset(w));
            else if (is_mapped(w)) check("R1 reset value", v, exp_reset(w));
            else check("R9 unmapped read", v, 0);
        end

        // R9 R2: writes to unmapped and ID offsets do nothing
        for (int w = 0; w < 1024; w++) begin
            if (!is_mapped(w)) begin
                wr32(12'(w * 4), 32'hFFFF_FFFF);
                check("R9 no strobe", {s_pop, s_push, s_tx, s_flush, s_brk, s_clr}, 0);
            end
        end
        for (int w = 0; w < 1024; w++) begin
            if (is_mapped(w) || w >= 12'h3F8) begin
                rd32(12'(w * 4), v);
                check(w >= 12'h3F8 ? "R2 id after write" : "R9 regs unchanged", v, exp_reset(w));
            end
        end

        // R8: field widths
        wr32(12'h024, 32'hFFFF_FFFF); rd32(12'h024, v); check("R8 int divisor", v, 32'hFFFF);
        wr32(12'h028, 32'hFFFF_FFFF); rd32(12'h028, v); check("R8 frac divisor", v, 32'h3F);
        wr32(12'h034, 32'hFFFF_FFFF); rd32(12'h034, v); check("R8 level", v, 32'h3F);
        wr32(12'h048, 32'hFFFF_FFFF); rd32(12'h048, v); check("R8 dma", v, 32'h7);
        wr32(12'h020, 32'hFFFF_FFFF); rd32(12'h020, v); check("R8 lpdiv", v, 32'hFF);
        wr32(12'h038, 32'hFFFF_FFFF); rd32(12'h038, v); check("R8 mask", v, 32'h7FF);
        check("R8 baud_frac port", baud_frac, 6'h3F);

        // R10: masked status sweep, clear strobe, read-only status
        for (int m = 0; m < 11; m++) begin
            logic [10:0] mk;
            mk = 11'(11'h0F3 << m);
            ris = 11'h555 ^ 11'(m * 37);
            wr32(12'h038, {21'h0, mk});
            rd32(12'h040, v);
            check("R10 masked status", v, {21'h0, ris & mk});
        end
        wr32(12'h03C, 32'h0); wr32(12'h040, 32'h0);
        rd32(12'h03C, v); check("R10 raw ignores write", v, {21'h0, ris});
        rd32(12'h038, v); check("R10 mask kept", v, {21'h0, 11'(11'h0F3 << 10)});
        wr32(12'h044, 32'h0000_0123);
        check("R10 clear strobe", s_clr, 1);
        check("R10 clear bits", s_clrbits, 11'h123);

        // R3 R4: data read pops and latches errors
        rx_empty = 0;
        for (int e = 0; e < 16; e++) begin
            rx_head = {4'(e), 8'(e * 17 + 3)};
            rd32(12'h000, v);
            check("R3 data value", v, {20'h0, rx_head});
            check("R3 pop", s_pop, 1);
            rd32(12'h004, v);
            check("R3 status latch", v, e);
            check("R11 setup quiet", s_setup, 0);
        end
        wr32(12'h004, 32'h0); rd32(12'h004, v); check("R4 status clear", v, 0);
        rx_empty = 1; rx_head = 12'hB00;
        rd32(12'h000, v); check("R3 no pop when empty", s_pop, 0);
        rx_empty = 0; rx_full = 1; tx_empty = 0; tx_full = 1; tx_busy = 1;
        wr32(12'h018, 32'h0);
        rd32(12'h018, v); check("R4 flags layout", v, 32'h68);
        rx_empty = 1; rx_full = 0; tx_empty = 1; tx_full = 0; tx_busy = 0;

        // R7: transmit writes
        wr32(12'h030, 32'h0);
        wr32(12'h000, 32'h0000_01C3);
        check("R7 tx push", s_tx, 1); check("R7 tx byte", s_byte, 8'hC3);
        check("R7 no loop push", s_push, 0);
        wr32(12'h030, 32'h80);
        wr32(12'h000, 32'h0000_007E);
        check("R7 loop push", s_push, 1); check("R7 loop word", s_word, 12'h07E);

        // R5 R6: line control transitions (loopback on)
        wr32(12'h02C, 32'h10);
        check("R5 flush on enable", s_flush, 1); check("R6 no toggle", s_brk, 0);
        check("R11 setup quiet", s_setup, 0);
        wr32(12'h02C, 32'h10);
        check("R5 no flush same", s_flush, 0);
        wr32(12'h02C, 32'h11);
        check("R6 toggle set", s_brk, 1); check("R5 no flush", s_flush, 0);
        check("R6 break push", s_push, 1); check("R6 break word", s_word, 12'h400);
        check("R6 line port", line_ctrl, 8'h11);
        wr32(12'h02C, 32'h10);
        check("R6 toggle clear", s_brk, 1); check("R6 no push on clear", s_push, 0);
        wr32(12'h030, 32'h0);
        wr32(12'h02C, 32'h11);
        check("R6 toggle no lb", s_brk, 1); check("R6 no push no lb", s_push, 0);
        wr32(12'h02C, 32'h00);
        check("R5 flush on disable", s_flush, 1); check("R6 toggle", s_brk, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule